// File: doc/BRIEF.md
# Search-Engine Read Response Controller

This block is the device-side responder for host read instructions on a shared, bidirectional data bus. The host presents a read command, qualified by a command-valid strobe, together with a word on the data bus. That word carries a device-select field and, for a single read, the word address. The controller compares the select field with its own strapped identity and answers only when the two match. It also answers when the select field is all ones and the device is strapped as the last one in the chain.

A single read returns one word. A burst read returns a run of words taken from an auto-incrementing burst pointer. The host loads that pointer, with a length, before it issues the burst. Turnaround follows a fixed schedule that is exact to the cycle. The host owns the bus in the command cycle, and the next two cycles are left undriven. The device then drives ACK low for one cycle and drives ACK high alongside each data word. In the final cycle it floats the bus, drives ACK low, and afterwards releases ACK to high-Z. During a burst, an end-of-transfer line (EOT) follows the same drive window and marks the last word.

Separate output-enable signals represent every tri-state line, so a surrounding pad ring or a testbench can see exactly when each line is released. The storage is a small behavioural register file with a plain write port.

Top module: `srch_rd_resp`

## Requirements
- R1: A read is accepted only in a cycle where the controller is idle, `cmd_valid` is 1 and `cmd[1:0]` is 2'b00. Other opcodes, and cycles with `cmd_valid` at 0, cause no bus activity. After reset, every output enable is 0.
- R2: The device is selected when `dq_in[25:21]` equals `dev_id`.
- R3: When `dq_in[25:21]` is 5'b11111, the device answers only if `last_dev` is 1. With `last_dev` at 0 it stays silent, even if `dev_id` is also 5'b11111.
- R4: A single read (`cmd[2]`=0) takes six cycles, counting the command cycle as cycle 1. In cycles 2 and 3 all enables are 0. In cycle 4 the bus is driven with ACK driven low. In cycle 5 the data word is driven with ACK high. In cycle 6 the bus enable is 0 and ACK is driven low. From cycle 7 the ACK enable is 0. EOT is never driven in a single read.
- R5: A single read returns the stored word at the address `dq_in[5:0]` captured in cycle 1.
- R6: A burst read (`cmd[2]`=1) of n accesses lasts 4+2n cycles. Each access is a pair of cycles: a driven cycle with ACK low, then a data cycle with ACK high. The last cycle floats the bus with ACK driven low.
- R7: In a burst, EOT is driven low from cycle 4 onward. It is high only on the data cycle of the final access, and it is driven low in cycle 4+2n. Its enable is 0 from cycle 5+2n.
- R8: Burst words come from consecutive addresses, starting at the pointer and wrapping modulo the depth. The pointer advances by one after each data cycle and keeps its value between bursts, so an unreloaded burst continues where the previous one stopped.
- R9: A burst length of 0 is served as one access.
- R10: While unselected, the device never asserts `dq_oe`, `ack_oe` or `eot_oe`.
- R11: Commands presented while a read is in progress are ignored and do not alter the ongoing response.
- R12: A `burst_ld` pulse sets the pointer to `burst_start` and the length to `burst_len`.

Ports and register-file writes (`mem_we`) store `mem_wdata` at `mem_waddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command qualifier |
| cmd | input | 3 | [1:0] opcode (2'b00 = read), [2] burst select |
| dq_in | input | 68 | Host-driven bus value: [25:21] select, [5:0] address |
| dev_id | input | 5 | Strapped device identity |
| last_dev | input | 1 | Strap: last device in the chain |
| burst_ld | input | 1 | Load burst pointer and length |
| burst_start | input | 6 | Burst start address |
| burst_len | input | 6 | Burst access count |
| mem_we | input | 1 | Register-file write enable |
| mem_waddr | input | 6 | Register-file write address |
| mem_wdata | input | 68 | Register-file write data |
| dq_out | output | 68 | Device-driven bus value |
| dq_oe | output | 1 | Bus output enable |
| ack_out | output | 1 | ACK value |
| ack_oe | output | 1 | ACK output enable |
| eot_out | output | 1 | EOT value |
| eot_oe | output | 1 | EOT output enable |

## Verification
The bench targets the corner cases where a bus device most often goes wrong.

- The broadcast select with and without the last-device strap: a design that treated 5'b11111 as an ordinary identity would drive a bus that another device owns.
- A zero burst length: a design that took it literally would never raise EOT, or would underflow its counter into a very long burst.
- A burst that wraps past the top address, and a second burst issued without reloading the pointer: these expose a pointer that fails to wrap, restarts from the start address, or steps in the wrong cycle.
- Commands injected during a response, and opcodes other than read: a design that fails these would restart its schedule mid-transfer or drive the bus when it should stay silent.

// File: rtl/srch_rd_resp_pkg.sv
// Shared definitions for the read response controller.
// Assumes: read opcode encoding is fixed at 2'b00 on the low command bits.
package srch_rd_resp_pkg;
    localparam logic [1:0] OP_READ = 2'b00;

    // Response schedule phases; each phase lasts exactly one clock.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_GAP_A = 3'd1,
        PH_GAP_B = 3'd2,
        PH_LEAD  = 3'd3,
        PH_BEAT  = 3'd4,
        PH_TAIL  = 3'd5
    } phase_t;
endpackage

// File: rtl/srch_rd_sel.sv
// Device-select decoder.
// Compares the select field of the bus word with the strapped identity.
// The all-ones field is a broadcast that only the last device may answer.
// Assumes: purely combinational, result is qualified by the sequencer.
module srch_rd_sel #(
    parameter int IDW = 5
) (
    input  logic [IDW-1:0] sel_field,
    input  logic [IDW-1:0] dev_id,
    input  logic           last_dev,
    output logic           hit
);
    localparam logic [IDW-1:0] BCAST = '1;

    // Decide whether this device owns the addressed transaction.
    always_comb begin
        if (sel_field == BCAST) hit = last_dev;
        else                    hit = (sel_field == dev_id);
    end
endmodule

// File: rtl/srch_rd_burst.sv
// Burst pointer and length register.
// A load pulse sets start address and length; each served burst word
// advances the pointer by one, wrapping at the address width.
// Assumes: load has priority over a step in the same cycle.
module srch_rd_burst #(
    parameter int AW = 6,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [LW-1:0] len
);
    // Hold and advance the burst pointer; capture the programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            len <= '0;
        end else if (load) begin
            ptr <= load_addr;
            len <= load_len;
        end else if (step) begin
            ptr <= ptr + AW'(1);
        end
    end

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ptr == AW'($past(ptr) + AW'(1)));

    // R12
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_addr) && len == $past(load_len)));
endmodule

// File: rtl/srch_rd_mem.sv
// Behavioural register file holding the searchable words.
// One synchronous write port, one asynchronous read port.
// Assumes: contents are not reset; the host writes before reading.
module srch_rd_mem #(
    parameter int DW    = 68,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    // Store a word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the addressed word continuously.
    always_comb rdata = cells[raddr];
endmodule

// File: rtl/srch_rd_seq.sv
// Response sequencer.
// Runs the fixed turnaround: two undriven cycles, then ACK-low / data
// pairs (one for a single read, the programmed count for a burst), then
// a closing cycle with ACK (and EOT for bursts) low, then release.
// Assumes: start is already qualified by opcode, valid and select.
module srch_rd_seq
    import srch_rd_resp_pkg::*;
#(
    parameter int AW = 6,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          burst_req,
    input  logic [AW-1:0] single_addr,
    input  logic [LW-1:0] burst_len,
    input  logic [AW-1:0] burst_ptr,
    output logic          burst_step,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          data_phase,
    output logic          dq_oe,
    output logic          ack_out,
    output logic          ack_oe,
    output logic          eot_out,
    output logic          eot_oe
);
    phase_t        ph;
    logic          in_burst;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] left;
    logic          accept;
    logic          last_beat;

    assign accept    = start && (ph == PH_IDLE);
    assign last_beat = (left == LW'(1));

    // Advance the response schedule and count remaining accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            in_burst <= 1'b0;
            addr_q   <= '0;
            left     <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (accept) begin
                    ph       <= PH_GAP_A;
                    in_burst <= burst_req;
                    addr_q   <= single_addr;
                    if (!burst_req || burst_len == '0) left <= LW'(1);
                    else                               left <= burst_len;
                end
                PH_GAP_A: ph <= PH_GAP_B;
                PH_GAP_B: ph <= PH_LEAD;
                PH_LEAD:  ph <= PH_BEAT;
                PH_BEAT: begin
                    left <= left - LW'(1);
                    ph   <= last_beat ? PH_TAIL : PH_LEAD;
                end
                PH_TAIL:  ph <= PH_IDLE;
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    // Decode line drives and enables from the current phase.
    always_comb begin
        busy       = (ph != PH_IDLE);
        data_phase = (ph == PH_BEAT);
        dq_oe      = (ph == PH_LEAD) || (ph == PH_BEAT);
        ack_oe     = dq_oe || (ph == PH_TAIL);
        ack_out    = data_phase;
        eot_oe     = in_burst && ack_oe;
        eot_out    = in_burst && data_phase && last_beat;
        burst_step = in_burst && data_phase;
        rd_addr    = in_burst ? burst_ptr : addr_q;
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && !start) |=> ph == PH_IDLE);

    // R4
    gap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_GAP_A) |=> (ph == PH_GAP_B && !ack_oe && !dq_oe));

    // R4
    ack_with_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ack_oe);

    // R6
    beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !last_beat) |=> (dq_oe && !ack_out));

    // R7
    eot_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_oe && eot_out) |=> (eot_oe && !eot_out && ack_oe && !ack_out && !dq_oe));

    // R11
    busy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_GAP_B) |=> ph == PH_LEAD);
endmodule

// File: rtl/srch_rd_resp.sv
// Read response controller top.
// Qualifies host read commands, selects this device by identity or by
// last-device broadcast, and returns single or burst data with exact
// tri-state timing on the data bus, ACK and EOT.
// Assumes: DEPTH is a power of two; address sits in the low bus bits.
module srch_rd_resp
    import srch_rd_resp_pkg::*;
#(
    parameter int DW      = 68,
    parameter int DEPTH   = 64,
    parameter int IDW     = 5,
    parameter int SEL_LSB = 21,
    parameter int LW      = 6,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd,
    input  logic [DW-1:0]  dq_in,
    input  logic [IDW-1:0] dev_id,
    input  logic           last_dev,
    input  logic           burst_ld,
    input  logic [AW-1:0]  burst_start,
    input  logic [LW-1:0]  burst_len,
    input  logic           mem_we,
    input  logic [AW-1:0]  mem_waddr,
    input  logic [DW-1:0]  mem_wdata,
    output logic [DW-1:0]  dq_out,
    output logic           dq_oe,
    output logic           ack_out,
    output logic           ack_oe,
    output logic           eot_out,
    output logic           eot_oe
);
    logic          sel_hit;
    logic          start;
    logic [AW-1:0] ptr;
    logic [LW-1:0] len;
    logic          step;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;
    logic          busy;
    logic          data_phase;

    srch_rd_sel #(.IDW(IDW)) i_sel (
        .sel_field (dq_in[SEL_LSB +: IDW]),
        .dev_id    (dev_id),
        .last_dev  (last_dev),
        .hit       (sel_hit)
    );

    // Qualify a read request for this device.
    always_comb start = cmd_valid && (cmd[1:0] == OP_READ) && sel_hit;

    srch_rd_burst #(.AW(AW), .LW(LW)) i_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (burst_ld),
        .load_addr (burst_start),
        .load_len  (burst_len),
        .step      (step),
        .ptr       (ptr),
        .len       (len)
    );

    srch_rd_mem #(.DW(DW), .DEPTH(DEPTH)) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    srch_rd_seq #(.AW(AW), .LW(LW)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .burst_req   (cmd[2]),
        .single_addr (dq_in[AW-1:0]),
        .burst_len   (len),
        .burst_ptr   (ptr),
        .burst_step  (step),
        .rd_addr     (rd_addr),
        .busy        (busy),
        .data_phase  (data_phase),
        .dq_oe       (dq_oe),
        .ack_out     (ack_out),
        .ack_oe      (ack_oe),
        .eot_out     (eot_out),
        .eot_oe      (eot_oe)
    );

    // Put the addressed word on the bus only in a data cycle.
    always_comb dq_out = data_phase ? rd_word : '0;

    // R10
    quiet_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(dq_oe || ack_oe || eot_oe));

    // R4
    ack_high_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && ack_out) |-> dq_oe);

    // R7
    eot_inside_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot_oe |-> ack_oe);
endmodule

// File: tb/test_srch_rd_resp.sv
// Scoreboard bench: the driver pushes the expected per-cycle line state
// for every issued command; the monitor pops one entry per clock at the
// falling edge and compares it with the outputs.
module test_srch_rd_resp;
    localparam int DW = 68;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int LW = 6;
    localparam logic [4:0] MY_ID = 5'd9;

    typedef struct {
        bit            dq_oe;
        bit            ack_oe;
        bit            ack;
        bit            eot_oe;
        bit            eot;
        bit            chk_dq;
        logic [DW-1:0] dq;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd = '0;
    logic [DW-1:0] dq_in = '0;
    logic [4:0] dev_id = MY_ID;
    logic last_dev = 1'b0;
    logic burst_ld = 1'b0;
    logic [AW-1:0] burst_start = '0;
    logic [LW-1:0] burst_len = '0;
    logic mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, ack_out, ack_oe, eot_out, eot_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    exp_t q[$];
    logic [DW-1:0] model [DEPTH];
    logic [AW-1:0] m_ptr = '0;
    logic [LW-1:0] m_len = '0;

    always #10 clk = ~clk;

    srch_rd_resp i_srch_rd_resp (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
        .dev_id(dev_id), .last_dev(last_dev), .burst_ld(burst_ld),
        .burst_start(burst_start), .burst_len(burst_len), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .dq_out(dq_out), .dq_oe(dq_oe),
        .ack_out(ack_out), .ack_oe(ack_oe), .eot_out(eot_out), .eot_oe(eot_oe)
    );

    function automatic logic [DW-1:0] pat(int i);
        logic [31:0] a;
        logic [31:0] b;
        a = 32'h9E3779B1 * (i + 7);
        b = 32'h5A00_0000 + i;
        return {i[3:0] ^ 4'h5, a, b};
    endfunction

    function automatic exp_t mk(bit d, bit ao, bit a, bit eo, bit e, bit cd,
                                logic [DW-1:0] w, string t);
        exp_t r;
        r.dq_oe = d; r.ack_oe = ao; r.ack = a; r.eot_oe = eo; r.eot = e;
        r.chk_dq = cd; r.dq = w; r.tag = t;
        return r;
    endfunction

    task automatic check1(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: one scoreboard entry per cycle, sampled mid-cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check1(dq_oe == e.dq_oe, e.tag, "dq_oe", DW'(dq_oe), DW'(e.dq_oe));
            check1(ack_oe == e.ack_oe, e.tag, "ack_oe", DW'(ack_oe), DW'(e.ack_oe));
            if (e.ack_oe) check1(ack_out == e.ack, e.tag, "ack", DW'(ack_out), DW'(e.ack));
            check1(eot_oe == e.eot_oe, e.tag, "eot_oe", DW'(eot_oe), DW'(e.eot_oe));
            if (e.eot_oe) check1(eot_out == e.eot, e.tag, "eot", DW'(eot_out), DW'(e.eot));
            if (e.chk_dq) check1(dq_out == e.dq, e.tag, "dq", dq_out, e.dq);
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic load_burst(int start, int len);
        @(negedge clk);
        burst_ld = 1'b1; burst_start = AW'(start); burst_len = LW'(len);
        @(negedge clk);
        burst_ld = 1'b0;
        m_ptr = AW'(start); m_len = LW'(len);
    endtask

    // Driver: present one command, push its expected response, optionally
    // poke extra commands while busy (R11), then wait for the scoreboard.
    task automatic issue(bit v, logic [2:0] c, logic [4:0] sel, int addr, bit poke, string tag);
        bit hit;
        bit acc;
        int beats;
        @(negedge clk);
        cmd_valid = v; cmd = c;
        dq_in = '0; dq_in[25:21] = sel; dq_in[AW-1:0] = AW'(addr);
        @(posedge clk);
        hit = (sel == 5'b11111) ? last_dev : (sel == dev_id);
        acc = v && (c[1:0] == 2'b00) && hit;
        if (!acc) begin
            for (int k = 0; k < 7; k++) q.push_back(mk(0, 0, 0, 0, 0, 0, '0, tag));
        end else begin
            q.push_back(mk(0, 0, 0, 0, 0, 0, '0, tag));
            q.push_back(mk(0, 0, 0, 0, 0, 0, '0, tag));
            if (!c[2]) begin
                q.push_back(mk(1, 1, 0, 0, 0, 0, '0, tag));
                q.push_back(mk(1, 1, 1, 0, 0, 1, model[addr % DEPTH], tag));
            end else begin
                beats = (m_len == 0) ? 1 : int'(m_len);
                for (int b = 0; b < beats; b++) begin
                    q.push_back(mk(1, 1, 0, 1, 0, 0, '0, tag));
                    q.push_back(mk(1, 1, 1, 1, b == beats - 1, 1, model[m_ptr], tag));
                    m_ptr = m_ptr + AW'(1);
                end
            end
            q.push_back(mk(0, 1, 0, c[2], 0, 0, '0, tag));
            q.push_back(mk(0, 0, 0, 0, 0, 0, '0, tag));
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd = '0; dq_in = '0;
        if (poke) begin
            cmd_valid = 1'b1; cmd = 3'b100; dq_in[25:21] = dev_id; dq_in[3:0] = 4'hF;
            @(negedge clk);
            cmd_valid = 1'b1; cmd = 3'b000;
            @(negedge clk);
            cmd_valid = 1'b0; cmd = '0; dq_in = '0;
        end
        while (q.size() != 0) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset leaves all lines released
        check1(!dq_oe && !ack_oe && !eot_oe, "R1", "reset enables",
               DW'({dq_oe, ack_oe, eot_oe}), '0);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = pat(i);
            model[i] = pat(i);
        end
        @(negedge clk);
        mem_we = 1'b0;

        issue(1, 3'b000, MY_ID, 5, 0, "R4 R5 R2 single addr 5");
        issue(1, 3'b000, MY_ID, 63, 0, "R4 R5 single top addr");
        issue(1, 3'b000, 5'd10, 7, 0, "R10 R2 other id");
        issue(1, 3'b000, 5'b11111, 8, 0, "R3 R10 broadcast not last");
        issue(1, 3'b001, MY_ID, 9, 0, "R1 other opcode");
        issue(0, 3'b000, MY_ID, 9, 0, "R1 valid low");
        last_dev = 1'b1;
        issue(1, 3'b000, 5'b11111, 12, 0, "R3 broadcast last");
        last_dev = 1'b0;
        issue(1, 3'b000, MY_ID, 20, 1, "R11 busy poke single");
        load_burst(10, 3);
        issue(1, 3'b100, MY_ID, 0, 0, "R6 R7 R8 R12 burst 3");
        issue(1, 3'b100, MY_ID, 0, 0, "R8 burst continues");
        load_burst(62, 4);
        issue(1, 3'b100, MY_ID, 0, 1, "R8 R11 burst wrap poke");
        load_burst(33, 0);
        issue(1, 3'b100, MY_ID, 0, 0, "R9 zero length");
        issue(1, 3'b100, 5'd3, 0, 0, "R10 burst other id");
        load_burst(2, 1);
        issue(1, 3'b100, MY_ID, 0, 0, "R6 R7 single-beat burst");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule